// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block sits on the slave side of a host bus. It gives the host indirect access to two downstream spaces, video memory and the register space, through a 32-bit index register and a 4-byte data window. The host first writes the index. Each later access that lands in the window is forwarded to one of the two spaces. The top bit of the index picks memory or registers, and the lower bits give the target address.

The host bus carries a byte address, a size code and right-aligned data. Register traffic leaves on a word-addressed port with byte strobes. The block places write data in the right lanes and picks read data out of them. Memory traffic leaves on a byte-addressed port, little-endian and right-aligned, after a bounds check against the memory size. Host addresses outside the index and the window pass straight to the register port. Exactly one downstream transaction is made per host access, and the host response waits for it.

Top module: `index_window`

## Requirements
- R1: After reset the index register reads as 0, `host_req_ready` is 1, and `host_resp_valid`, `reg_req_valid` and `mem_req_valid` are 0.
- R2: Writes to the index word (`IDX_ADDR`, byte offset = `host_req_addr[1:0]`) replace only the addressed byte lanes of the index. Reads there return those lanes right-aligned. Index accesses make no downstream request.
- R3: A window access (`WIN_ADDR` word) with index bit 31 set goes to the memory port with address = index bits 30:0, the host size code, and write data masked to the access size. The window byte offset is ignored.
- R4: A memory access happens only when index[30:0] + size ≤ `MEM_BYTES`. Otherwise no memory request is made, a write is dropped and a read returns 0.
- R5: Memory read data is little-endian: the byte at the lowest address is in bits 7:0 of the response, and bytes beyond the access size read as 0.
- R6: A window access with index bit 31 clear goes to the register port. The target byte address is index + window byte offset. `reg_req_addr` is the target with bits 1:0 cleared, and the lane offset is target bits 1:0.
- R7: A register read returns the word bytes starting at lane offset × 8, right-aligned, with only size bytes kept. A 4-byte read at lane offset 0 returns the full word.
- R8: A register write asserts `reg_req_strb` bit b only for lanes offset ≤ b < offset + size, with data shifted to those lanes. Lanes past byte 3 are dropped.
- R9: A host access to any other address goes to the register port with its own word address and lane offset.
- R10: One downstream request is made per forwarded host access. `host_req_ready` drops after acceptance. A downstream valid and its fields are held until ready. `host_resp_valid` is a one-cycle pulse that follows the downstream response, and the two downstream valids are never high together.
- R11: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req_valid | input | 1 | Host access request |
| host_req_ready | output | 1 | Block idle, request accepted this cycle |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | HOST_AW | Host byte address |
| host_req_size | input | 2 | Size code (R11) |
| host_req_wdata | input | 32 | Right-aligned write data |
| host_resp_valid | output | 1 | Response pulse |
| host_resp_rdata | output | 32 | Right-aligned read data (0 for writes) |
| reg_req_valid | output | 1 | Register request |
| reg_req_ready | input | 1 | Register port accepts |
| reg_req_write | output | 1 | Register write |
| reg_req_addr | output | REG_AW | Word-aligned register byte address |
| reg_req_strb | output | 4 | Byte-lane strobes |
| reg_req_wdata | output | 32 | Lane-placed write data |
| reg_rsp_valid | input | 1 | Register response |
| reg_rsp_rdata | input | 32 | Full register word |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory port accepts |
| mem_req_write | output | 1 | Memory write |
| mem_req_addr | output | MEM_AW | Memory byte address |
| mem_req_size | output | 2 | Size code |
| mem_req_wdata | output | 32 | Right-aligned little-endian write data |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_rdata | input | 32 | Right-aligned little-endian read data |

## Verification
The bench builds the block with 8-bit host and register addresses, a 64-byte memory, the index at 0x40 and the window at 0x44. With a memory that small, every index from 56 to 63 can be swept against every size, so each side of the bound (index + size = 64 versus 65) is hit for 1, 2 and 4 bytes. The register sweep covers four index values with the low bits 0 to 3, all four window offsets and all sizes. This reaches every lane offset, including the cases where lanes run past byte 3. Downstream latencies rotate between zero and two cycles.

// File: rtl/ixw_pkg.sv
package ixw_pkg;

  typedef enum logic [1:0] {
    RT_INDEX,
    RT_REG,
    RT_MEM
  } route_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REG_REQ,
    ST_REG_RSP,
    ST_MEM_REQ,
    ST_MEM_RSP,
    ST_DONE
  } state_t;

  // size code to byte count: 0->1, 1->2, else 4
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // low n bytes set
  function automatic logic [31:0] byte_mask(input logic [2:0] n);
    logic [5:0] sh;
    sh = 6'd32 - {n, 3'b000};
    return 32'hFFFF_FFFF >> sh;
  endfunction

  // lanes off .. off+n-1, clipped at lane 3
  function automatic logic [3:0] lane_strb(input logic [1:0] off, input logic [2:0] n);
    logic [7:0] w;
    w = (8'd1 << n) - 8'd1;
    w = w << off;
    return w[3:0];
  endfunction

  function automatic logic [31:0] lane_place(input logic [31:0] data, input logic [1:0] off);
    return data << {off, 3'b000};
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] word, input logic [1:0] off,
                                            input logic [2:0] n);
    return (word >> {off, 3'b000}) & byte_mask(n);
  endfunction

  function automatic logic fits_mem(input logic [30:0] idx, input logic [2:0] n,
                                    input int unsigned lim);
    return (33'(idx) + 33'(n)) <= 33'(lim);
  endfunction

endpackage

// File: rtl/ixw_route.sv
module ixw_route
  import ixw_pkg::*;
#(
  parameter int HOST_AW = 14,
  parameter int REG_AW = 14,
  parameter int MEM_AW = 24,
  parameter int unsigned MEM_BYTES = 32'h0100_0000,
  parameter logic [HOST_AW-1:0] IDX_ADDR = '0,
  parameter logic [HOST_AW-1:0] WIN_ADDR = HOST_AW'(4)
) (
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [1:0]         host_size,
  input  logic [31:0]        index,
  output route_t             route,
  output logic [REG_AW-1:0]  reg_word,
  output logic [1:0]         lane_off,
  output logic [2:0]         nbytes,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic               mem_fit
);

  logic              hit_idx;
  logic              hit_win;
  logic [REG_AW-1:0] direct;
  logic [REG_AW-1:0] wsum;

  assign hit_idx = host_addr[HOST_AW-1:2] == IDX_ADDR[HOST_AW-1:2];
  assign hit_win = host_addr[HOST_AW-1:2] == WIN_ADDR[HOST_AW-1:2];
  assign direct  = REG_AW'(host_addr);
  assign wsum    = index[REG_AW-1:0] + REG_AW'(host_addr[1:0]);

  always_comb begin
    nbytes = size_bytes(host_size);
    if (hit_idx) begin
      route    = RT_INDEX;
      lane_off = host_addr[1:0];
      reg_word = {direct[REG_AW-1:2], 2'b00};
    end else if (hit_win && index[31]) begin
      route    = RT_MEM;
      lane_off = 2'd0;
      reg_word = {direct[REG_AW-1:2], 2'b00};
    end else if (hit_win) begin
      route    = RT_REG;
      lane_off = wsum[1:0];
      reg_word = {wsum[REG_AW-1:2], 2'b00};
    end else begin
      route    = RT_REG;
      lane_off = host_addr[1:0];
      reg_word = {direct[REG_AW-1:2], 2'b00};
    end
  end

  assign mem_addr = index[MEM_AW-1:0];
  assign mem_fit  = fits_mem(index[30:0], nbytes, MEM_BYTES);

endmodule

// File: rtl/ixw_ctrl.sv
module ixw_ctrl
  import ixw_pkg::*;
#(
  parameter int REG_AW = 14,
  parameter int MEM_AW = 24,
  parameter int unsigned MEM_BYTES = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [1:0]        host_req_size,
  input  logic [31:0]       host_req_wdata,
  output logic              host_resp_valid,
  output logic [31:0]       host_resp_rdata,
  input  route_t            route,
  input  logic [REG_AW-1:0] reg_word,
  input  logic [1:0]        lane_off,
  input  logic [2:0]        nbytes,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_fit,
  output logic [31:0]       index_q,
  output logic              reg_req_valid,
  input  logic              reg_req_ready,
  output logic              reg_req_write,
  output logic [REG_AW-1:0] reg_req_addr,
  output logic [3:0]        reg_req_strb,
  output logic [31:0]       reg_req_wdata,
  input  logic              reg_rsp_valid,
  input  logic [31:0]       reg_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [MEM_AW-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata
);

  state_t            state;
  logic              wr_q;
  logic [1:0]        off_q;
  logic [2:0]        n_q;
  logic [REG_AW-1:0] raddr_q;
  logic [3:0]        strb_q;
  logic [31:0]       rwd_q;
  logic [MEM_AW-1:0] maddr_q;
  logic [1:0]        msize_q;
  logic [31:0]       mwd_q;
  logic [31:0]       rdata_q;
  logic [7:0]        idx_b [4];

  // named events
  logic        accept;
  logic        idx_we;
  logic        mem_drop;
  logic [3:0]  wr_strb;
  logic [31:0] wr_place;

  assign host_req_ready = (state == ST_IDLE);
  assign accept   = host_req_valid && host_req_ready;
  assign idx_we   = accept && (route == RT_INDEX) && host_req_write;
  assign mem_drop = accept && (route == RT_MEM) && !mem_fit;
  assign wr_strb  = lane_strb(lane_off, nbytes);
  assign wr_place = lane_place(host_req_wdata, lane_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) idx_b[b] <= 8'h00;
    end else if (idx_we) begin
      for (int b = 0; b < 4; b++)
        if (wr_strb[b]) idx_b[b] <= wr_place[8*b +: 8];
    end
  end

  assign index_q = {idx_b[3], idx_b[2], idx_b[1], idx_b[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wr_q    <= 1'b0;
      off_q   <= '0;
      n_q     <= '0;
      raddr_q <= '0;
      strb_q  <= '0;
      rwd_q   <= '0;
      maddr_q <= '0;
      msize_q <= '0;
      mwd_q   <= '0;
      rdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            wr_q    <= host_req_write;
            off_q   <= lane_off;
            n_q     <= nbytes;
            raddr_q <= reg_word;
            strb_q  <= wr_strb;
            rwd_q   <= host_req_write ? wr_place : 32'h0;
            maddr_q <= mem_addr;
            msize_q <= host_req_size;
            mwd_q   <= host_req_write ? (host_req_wdata & byte_mask(nbytes)) : 32'h0;
            case (route)
              RT_INDEX: begin
                rdata_q <= host_req_write ? 32'h0 : lane_pick(index_q, lane_off, nbytes);
                state   <= ST_DONE;
              end
              RT_REG: state <= ST_REG_REQ;
              RT_MEM: begin
                if (mem_fit) begin
                  state <= ST_MEM_REQ;
                end else begin
                  rdata_q <= 32'h0;
                  state   <= ST_DONE;
                end
              end
              default: begin
                rdata_q <= 32'h0;
                state   <= ST_DONE;
              end
            endcase
          end
        end
        ST_REG_REQ: if (reg_req_ready) state <= ST_REG_RSP;
        ST_REG_RSP: begin
          if (reg_rsp_valid) begin
            rdata_q <= wr_q ? 32'h0 : lane_pick(reg_rsp_rdata, off_q, n_q);
            state   <= ST_DONE;
          end
        end
        ST_MEM_REQ: if (mem_req_ready) state <= ST_MEM_RSP;
        ST_MEM_RSP: begin
          if (mem_rsp_valid) begin
            rdata_q <= wr_q ? 32'h0 : (mem_rsp_rdata & byte_mask(n_q));
            state   <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_resp_valid = (state == ST_DONE);
  assign host_resp_rdata = rdata_q;

  assign reg_req_valid = (state == ST_REG_REQ);
  assign reg_req_write = wr_q;
  assign reg_req_addr  = raddr_q;
  assign reg_req_strb  = strb_q;
  assign reg_req_wdata = rwd_q;

  assign mem_req_valid = (state == ST_MEM_REQ);
  assign mem_req_write = wr_q;
  assign mem_req_addr  = maddr_q;
  assign mem_req_size  = msize_q;
  assign mem_req_wdata = mwd_q;

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !host_req_ready);

  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_resp_valid |=> !host_resp_valid);

  assert_reg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && !reg_req_ready |=> reg_req_valid && $stable(reg_req_addr)
                                        && $stable(reg_req_strb) && $stable(reg_req_wdata));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                        && $stable(mem_req_size));

  assert_one_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req_valid && mem_req_valid));

  assert_mem_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (33'(mem_req_addr) + 33'(size_bytes(mem_req_size))) <= 33'(MEM_BYTES));

  assert_drop_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_drop |=> host_resp_valid && (host_resp_rdata == 32'h0) && !mem_req_valid);

  assert_strb_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid |-> reg_req_strb != 4'h0);

endmodule

// File: rtl/index_window.sv
module index_window
  import ixw_pkg::*;
#(
  parameter int HOST_AW = 14,
  parameter int REG_AW = 14,
  parameter int unsigned MEM_BYTES = 32'h0100_0000,
  parameter logic [HOST_AW-1:0] IDX_ADDR = '0,
  parameter logic [HOST_AW-1:0] WIN_ADDR = HOST_AW'(4),
  localparam int MEM_AW = $clog2(MEM_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req_valid,
  output logic               host_req_ready,
  input  logic               host_req_write,
  input  logic [HOST_AW-1:0] host_req_addr,
  input  logic [1:0]         host_req_size,
  input  logic [31:0]        host_req_wdata,
  output logic               host_resp_valid,
  output logic [31:0]        host_resp_rdata,
  output logic               reg_req_valid,
  input  logic               reg_req_ready,
  output logic               reg_req_write,
  output logic [REG_AW-1:0]  reg_req_addr,
  output logic [3:0]         reg_req_strb,
  output logic [31:0]        reg_req_wdata,
  input  logic               reg_rsp_valid,
  input  logic [31:0]        reg_rsp_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [MEM_AW-1:0]  mem_req_addr,
  output logic [1:0]         mem_req_size,
  output logic [31:0]        mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [31:0]        mem_rsp_rdata
);

  route_t            route;
  logic [REG_AW-1:0] reg_word;
  logic [1:0]        lane_off;
  logic [2:0]        nbytes;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_fit;
  logic [31:0]       index_q;

  ixw_route #(
    .HOST_AW(HOST_AW), .REG_AW(REG_AW), .MEM_AW(MEM_AW), .MEM_BYTES(MEM_BYTES),
    .IDX_ADDR(IDX_ADDR), .WIN_ADDR(WIN_ADDR)
  ) u_route (
    .host_addr(host_req_addr),
    .host_size(host_req_size),
    .index(index_q),
    .route(route),
    .reg_word(reg_word),
    .lane_off(lane_off),
    .nbytes(nbytes),
    .mem_addr(mem_addr),
    .mem_fit(mem_fit)
  );

  ixw_ctrl #(
    .REG_AW(REG_AW), .MEM_AW(MEM_AW), .MEM_BYTES(MEM_BYTES)
  ) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .host_req_valid(host_req_valid),
    .host_req_ready(host_req_ready),
    .host_req_write(host_req_write),
    .host_req_size(host_req_size),
    .host_req_wdata(host_req_wdata),
    .host_resp_valid(host_resp_valid),
    .host_resp_rdata(host_resp_rdata),
    .route(route),
    .reg_word(reg_word),
    .lane_off(lane_off),
    .nbytes(nbytes),
    .mem_addr(mem_addr),
    .mem_fit(mem_fit),
    .index_q(index_q),
    .reg_req_valid(reg_req_valid),
    .reg_req_ready(reg_req_ready),
    .reg_req_write(reg_req_write),
    .reg_req_addr(reg_req_addr),
    .reg_req_strb(reg_req_strb),
    .reg_req_wdata(reg_req_wdata),
    .reg_rsp_valid(reg_rsp_valid),
    .reg_rsp_rdata(reg_rsp_rdata),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  // reset state of the host side
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> host_req_ready && !host_resp_valid);

endmodule

// File: tb/tb_index_window.sv
module tb_index_window;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] IDX = 8'h40;
  localparam logic [7:0] WIN = 8'h44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req_valid = 1'b0, host_req_ready, host_req_write = 1'b0;
  logic [7:0] host_req_addr = '0;
  logic [1:0] host_req_size = '0;
  logic [31:0] host_req_wdata = '0;
  logic host_resp_valid;
  logic [31:0] host_resp_rdata;
  logic reg_req_valid, reg_req_ready, reg_req_write;
  logic [7:0] reg_req_addr;
  logic [3:0] reg_req_strb;
  logic [31:0] reg_req_wdata;
  logic reg_rsp_valid;
  logic [31:0] reg_rsp_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [5:0] mem_req_addr;
  logic [1:0] mem_req_size;
  logic [31:0] mem_req_wdata;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  index_window #(
    .HOST_AW(8), .REG_AW(8), .MEM_BYTES(64), .IDX_ADDR(IDX), .WIN_ADDR(WIN)
  ) dut (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;
  int reg_cnt = 0, mem_cnt = 0;
  logic [7:0] last_raddr;
  logic [3:0] last_strb;
  logic [5:0] last_maddr;
  logic [1:0] last_msize;
  logic [31:0] last_mwd;
  logic [31:0] regs [64];
  logic [31:0] exp_regs [64];
  logic [7:0] mb [64];
  logic [7:0] exp_mb [64];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] b_pick(input logic [31:0] w, input int off, input int n);
    logic [31:0] r = 0;
    for (int i = 0; i < n; i++)
      if (off + i < 4) r[8*i +: 8] = w[8*(off+i) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] b_dep(input logic [31:0] w, input int off, input int n,
                                        input logic [31:0] d);
    logic [31:0] r = w;
    for (int i = 0; i < n; i++)
      if (off + i < 4) r[8*(off+i) +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // register-side responder
  initial begin
    reg_req_ready = 0; reg_rsp_valid = 0; reg_rsp_rdata = 0;
    forever begin
      @(negedge clk);
      if (rst_n && reg_req_valid) begin
        int la, lb, w;
        logic wr;
        logic [31:0] wd;
        la = reg_cnt % 3; lb = (reg_cnt / 3) % 3;
        repeat (la) @(negedge clk);
        reg_req_ready = 1;
        last_raddr = reg_req_addr; last_strb = reg_req_strb;
        wr = reg_req_write; wd = reg_req_wdata;
        reg_cnt++;
        @(negedge clk);
        reg_req_ready = 0;
        w = int'(last_raddr[7:2]);
        if (wr)
          for (int b = 0; b < 4; b++)
            if (last_strb[b]) regs[w][8*b +: 8] = wd[8*b +: 8];
        repeat (lb) @(negedge clk);
        reg_rsp_rdata = wr ? 32'hDEAD_BEEF : regs[w];
        reg_rsp_valid = 1;
        @(negedge clk);
        reg_rsp_valid = 0;
      end
    end
  end

  // memory-side responder
  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = 0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        int la, lb, a;
        logic wr;
        la = (mem_cnt + 1) % 3; lb = mem_cnt % 2;
        repeat (la) @(negedge clk);
        mem_req_ready = 1;
        last_maddr = mem_req_addr; last_msize = mem_req_size; last_mwd = mem_req_wdata;
        wr = mem_req_write;
        mem_cnt++;
        @(negedge clk);
        mem_req_ready = 0;
        a = int'(last_maddr);
        if (wr)
          for (int i = 0; i < nb(last_msize); i++) mb[(a+i) % 64] = last_mwd[8*i +: 8];
        repeat (lb) @(negedge clk);
        for (int i = 0; i < 4; i++) mem_rsp_rdata[8*i +: 8] = mb[(a+i) % 64];
        mem_rsp_valid = 1;
        @(negedge clk);
        mem_rsp_valid = 0;
      end
    end
  end

  task automatic acc(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd);
    while (!host_req_ready) @(negedge clk);
    host_req_valid = 1; host_req_write = wr; host_req_addr = a;
    host_req_size = sz; host_req_wdata = wd;
    @(negedge clk);
    host_req_valid = 0;
    chk("R10 ready low while busy", {31'b0, host_req_ready}, 32'h0);
    while (!host_resp_valid) @(negedge clk);
    rd = host_resp_rdata;
    @(negedge clk);
    chk("R10 response is one pulse", {31'b0, host_resp_valid}, 32'h0);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd, exp_idx, pat, e;
    int rb, mbf;
    for (int i = 0; i < 64; i++) begin
      regs[i] = {8'(i) ^ 8'h5A, 8'(i + 1), ~8'(i), 8'(i * 3)};
      exp_regs[i] = regs[i];
      mb[i] = 8'(i * 13 + 5);
      exp_mb[i] = mb[i];
    end
    repeat (4) @(negedge clk);
    chk("R1 ready in reset", {31'b0, host_req_ready}, 32'h1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, host_req_ready}, 32'h1);
    chk("R1 no response", {31'b0, host_resp_valid}, 32'h0);
    chk("R1 no downstream", {30'b0, reg_req_valid, mem_req_valid}, 32'h0);
    acc(0, IDX, 2'd2, 0, rd);
    chk("R1 index reset value", rd, 32'h0);

    // index register lanes
    rb = reg_cnt; mbf = mem_cnt;
    exp_idx = 32'h1234_5678;
    acc(1, IDX, 2'd2, exp_idx, rd);
    for (int off = 0; off < 4; off++)
      for (int sz = 0; sz < 3; sz++) begin
        acc(0, IDX + 8'(off), 2'(sz), 0, rd);
        chk($sformatf("R2 R11 index read off%0d sz%0d", off, sz), rd, b_pick(exp_idx, off, nb(2'(sz))));
      end
    for (int off = 0; off < 4; off++)
      for (int sz = 0; sz < 2; sz++) begin
        pat = 32'hA5C3_0000 | 32'(off * 16 + sz + 1) | (32'(off * 16 + sz + 9) << 8);
        acc(1, IDX + 8'(off), 2'(sz), pat, rd);
        exp_idx = b_dep(exp_idx, off, nb(2'(sz)), pat);
        acc(0, IDX, 2'd2, 0, rd);
        chk($sformatf("R2 partial index write off%0d sz%0d", off, sz), rd, exp_idx);
      end
    chk("R2 index makes no downstream request", 32'(reg_cnt - rb + mem_cnt - mbf), 32'h0);

    // memory window
    for (int k = 0; k < 14; k++) begin
      int a, n;
      bit fit;
      a = (k < 4) ? k : (k < 12) ? 52 + k : (k == 12) ? 64 : 32'h7FFF_FFFF;
      for (int sz = 0; sz < 3; sz++) begin
        n = nb(2'(sz));
        fit = (longint'(a) + n) <= 64;
        acc(1, IDX, 2'd2, 32'h8000_0000 | 32'(a), rd);
        pat = 32'hC0DE_0000 ^ (32'(a) << 8) ^ 32'(sz * 7 + 1) ^ 32'h1100_0000;
        mbf = mem_cnt;
        acc(1, WIN + 8'(a % 4), 2'(sz), pat, rd);
        chk($sformatf("R4 mem write issued a%0d n%0d", a, n), 32'(mem_cnt - mbf), fit ? 32'h1 : 32'h0);
        if (fit) begin
          chk("R3 mem address from index", 32'(last_maddr), 32'(a));
          chk("R3 R11 mem size code", 32'(last_msize), 32'(sz));
          chk("R3 mem wdata masked", last_mwd, b_pick(pat, 0, n));
          for (int i = 0; i < n; i++) exp_mb[a + i] = pat[8*i +: 8];
        end
        mbf = mem_cnt;
        acc(0, WIN + 8'((a + 1) % 4), 2'(sz), 0, rd);
        e = 0;
        if (fit) for (int i = 0; i < n; i++) e[8*i +: 8] = exp_mb[a + i];
        chk($sformatf("R4 R5 mem read a%0d n%0d", a, n), rd, e);
        chk("R4 mem read issued", 32'(mem_cnt - mbf), fit ? 32'h1 : 32'h0);
      end
    end

    // register window and direct access
    for (int base = 16; base < 20; base++)
      for (int wo = 0; wo < 4; wo++)
        for (int sz = 0; sz < 3; sz++) begin
          int t, w, o, n;
          t = base + wo; w = t / 4; o = t % 4; n = nb(2'(sz));
          acc(1, IDX, 2'd2, 32'(base), rd);
          pat = 32'h8844_2211 ^ (32'(t) << 4) ^ (32'(sz) << 24) ^ 32'(wo * 5);
          rb = reg_cnt;
          acc(1, WIN + 8'(wo), 2'(sz), pat, rd);
          chk("R10 one reg request per access", 32'(reg_cnt - rb), 32'h1);
          chk($sformatf("R6 reg word addr t%0d", t), 32'(last_raddr), 32'(w * 4));
          chk($sformatf("R8 strobes o%0d n%0d", o, n), 32'(last_strb), 32'((((1 << n) - 1) << o) & 15));
          exp_regs[w] = b_dep(exp_regs[w], o, n, pat);
          acc(0, 8'(w * 4), 2'd2, 0, rd);
          chk($sformatf("R8 R9 word after write t%0d n%0d", t, n), rd, exp_regs[w]);
          chk("R9 direct address", 32'(last_raddr), 32'(w * 4));
          acc(0, WIN + 8'(wo), 2'(sz), 0, rd);
          chk($sformatf("R7 reg read o%0d n%0d", o, n), rd, b_pick(exp_regs[w], o, n));
        end
    acc(0, 8'h09, 2'd0, 0, rd);
    chk("R9 direct byte read", rd, b_pick(exp_regs[2], 1, 1));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule